// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is a 16-bit timer/counter with three output-compare channels. A clock-select stage decides what advances the count. It can be a one-cycle tick from an external prescaler, an edge on a pin that is not synchronous to the clock, or nothing at all. The counter has three modes. In free-running up-count it wraps at the full range. In clear-on-compare it restarts from zero at a programmed limit. In phase-correct it counts up and then down between zero and a turning value.

Each channel keeps a buffered compare value. The channel checks that value against the count on every timer tick. A match sets the channel's flag and moves its waveform output. The flags are collected in one register that software clears by writing ones. A mask register selects which flags raise the single interrupt line.

The direction state machine has two states. ST_UP moves to ST_DOWN on a tick where the count is at or above the turning value in a phase-correct mode. ST_DOWN moves to ST_UP on a tick where the count is zero. In the two non-PWM modes the machine is forced to ST_UP on every clock.

Top module: `tmr3_timer`

## Requirements
- R1: After reset the count, flags, mask, waveform outputs and interrupt line are all zero.
- R2: Clock-select field ctrl[3:2] chooses the count source: 1 selects `presc_tick`, 2 selects the pin, and 0 or 3 select nothing. With nothing selected, the count holds its value.
- R3: The pin passes through two synchronizing flops, then an edge detector. ctrl[4]=0 counts rising edges and ctrl[4]=1 counts falling edges. Each selected edge gives exactly one count step, and that step lands on the third clock edge after the pin changes.
- R4: Mode field ctrl[1:0]=0 counts up by one per tick and wraps from 16'hFFFF to 0. The wrapping tick sets flag bit 0.
- R5: Mode 1 counts up to the limit register (address 5). The tick taken at the limit returns the count to 0 and sets flag bit 0.
- R6: Modes 2 and 3 count up and then down. The turning value is a fixed 16'h00FF in mode 2 and the limit register in mode 3. The count reverses at the turning value and at zero, and the tick at zero sets flag bit 0.
- R7: When a tick occurs and the count equals channel i's compare value, flag bit i+1 is set.
- R8: In modes 0 and 1, a compare value written at address 2+i takes effect at once. In modes 2 and 3 it is held in a buffer and becomes active on the tick at the turning value.
- R9: In modes 0 and 1, a match toggles waveform bit i. In modes 2 and 3, a match sets the bit while counting up and clears it while counting down.
- R10: Writing the flag register (address 6) clears each flag written with 1. A flag that is set and not cleared stays set.
- R11: `irq` is high exactly when some flag bit and its mask bit (address 7) are both 1.
- R12: A write to address 1 loads the count with the written value. Reading an address returns the control byte, count, buffered compare values, limit, flags or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_tick | input | 1 | One-cycle tick from the prescaler |
| ext_pin | input | 1 | Asynchronous external count pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| wave_out | output | 3 | Compare waveform outputs |
| irq | output | 1 | Masked interrupt request |

## Verification
The embedded properties check several rules on every cycle:
- the count holds when there is no tick and no write;
- the count steps by exactly one in free-running mode, and a wrap leaves it at zero;
- two pin-derived ticks never fall on adjacent cycles;
- an active compare value never changes away from the turning point in PWM modes;
- an up-count match always leaves the output high;
- flags stay set until cleared.

Other behaviour only shows up through the bench's scenarios against its reference model: the moment the phase-correct direction reverses, clear-on-compare restart, where the delayed buffer load lands inside a down-count, the three-edge latency from the pin, and interrupt masking.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
    localparam int NCH = 3;
    localparam int NF  = NCH + 1;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_PC_FIX = 2'd2,
        MODE_PC_REG = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CS_OFF   = 2'd0,
        CS_PRESC = 2'd1,
        CS_PIN   = 2'd2,
        CS_NONE  = 2'd3
    } csel_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } dir_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_COUNT = 3'd1;
    localparam logic [2:0] A_CMP0  = 3'd2;
    localparam logic [2:0] A_TOP   = 3'd5;
    localparam logic [2:0] A_FLAG  = 3'd6;
    localparam logic [2:0] A_MASK  = 3'd7;
endpackage

// File: rtl/tmr3_clksel.sv
module tmr3_clksel
    import tmr3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  csel_e sel,
    input  logic  fall_edge,
    input  logic  presc_tick,
    input  logic  ext_pin,
    output logic  tick
);
    logic sync1, sync2, prev;
    logic pin_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= ext_pin;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    always_comb begin
        pin_edge = fall_edge ? (prev & ~sync2) : (sync2 & ~prev);
        unique case (sel)
            CS_PRESC: tick = presc_tick;
            CS_PIN:   tick = pin_edge;
            default:  tick = 1'b0;
        endcase
    end

    AST_ONE_PIN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == CS_PIN) |=> !(tick && sel == CS_PIN)); // R3
endmodule

// File: rtl/tmr3_core.sv
module tmr3_core
    import tmr3_pkg::*;
#(
    parameter int         W         = 16,
    parameter logic [W-1:0] FIXED_TOP = 16'h00FF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  mode_e        mode,
    input  logic [W-1:0] top_reg,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         ovf_evt,
    output logic         top_evt,
    output logic         pwm
);
    localparam logic [W-1:0] ONE = 1;

    dir_e         dir_nx;
    logic [W-1:0] cnt_nx;
    logic [W-1:0] top_val;

    assign pwm     = mode[1];
    assign top_val = (mode == MODE_PC_FIX) ? FIXED_TOP : top_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir <= ST_UP;
        else        dir <= dir_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end

    always_comb begin
        dir_nx  = pwm ? dir : ST_UP;
        cnt_nx  = cnt;
        ovf_evt = 1'b0;
        top_evt = 1'b0;
        if (tick) begin
            unique case (mode)
                MODE_NORMAL: begin
                    cnt_nx  = cnt + ONE;
                    ovf_evt = (cnt == '1);
                end
                MODE_CTC: begin
                    if (cnt == top_val) begin
                        cnt_nx  = '0;
                        ovf_evt = 1'b1;
                        top_evt = 1'b1;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
                default: begin
                    unique case (dir)
                        ST_UP: begin
                            if (cnt >= top_val) begin
                                top_evt = 1'b1;
                                dir_nx  = ST_DOWN;
                                cnt_nx  = (cnt == '0) ? cnt : cnt - ONE;
                            end else begin
                                cnt_nx = cnt + ONE;
                            end
                        end
                        ST_DOWN: begin
                            if (cnt == '0) begin
                                ovf_evt = 1'b1;
                                dir_nx  = ST_UP;
                                cnt_nx  = (top_val == '0) ? cnt : cnt + ONE;
                            end else begin
                                cnt_nx = cnt - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (cnt_wr) cnt_nx = cnt_wdata;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R2
    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MODE_NORMAL) |=> (cnt == $past(cnt) + ONE)); // R4
endmodule

// File: rtl/tmr3_chan.sv
module tmr3_chan
    import tmr3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  dir_e         dir,
    input  logic         top_evt,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] buf_val,
    output logic         match,
    output logic         wave
);
    logic [W-1:0] active;
    logic [W-1:0] cmp_val;

    assign cmp_val = pwm ? active : buf_val;
    assign match   = tick && (cnt == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '0;
            wave   <= 1'b0;
        end else begin
            if (!pwm || top_evt) active <= buf_val;
            if (match) wave <= pwm ? (dir == ST_UP) : ~wave;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !top_evt) |=> $stable(active)); // R8
    AST_WAVE_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && match && dir == ST_UP) |=> wave); // R9
endmodule

// File: rtl/tmr3_timer.sv
module tmr3_timer
    import tmr3_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] FIXED_TOP = 16'h00FF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           presc_tick,
    input  logic           ext_pin,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [2:0]     rd_addr,
    output logic [W-1:0]   rd_data,
    output logic [NCH-1:0] wave_out,
    output logic           irq
);
    logic [7:0]     ctrl_q;
    logic [W-1:0]   top_q;
    logic [NF-1:0]  flags_q, mask_q, flag_set, flag_clr;
    logic [W-1:0]   cmp_buf [NCH];
    logic [NCH-1:0] match;
    logic           tick, cnt_wr, ovf_evt, top_evt, pwm;
    logic [W-1:0]   cnt;
    dir_e           dir;
    mode_e          mode;

    assign mode   = mode_e'(ctrl_q[1:0]);
    assign cnt_wr = wr_en && (wr_addr == A_COUNT);

    tmr3_clksel u_clksel (
        .clk(clk), .rst_n(rst_n), .sel(csel_e'(ctrl_q[3:2])), .fall_edge(ctrl_q[4]),
        .presc_tick(presc_tick), .ext_pin(ext_pin), .tick(tick)
    );

    tmr3_core #(.W(W), .FIXED_TOP(FIXED_TOP)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .top_reg(top_q),
        .cnt_wr(cnt_wr), .cnt_wdata(wr_data), .cnt(cnt), .dir(dir),
        .ovf_evt(ovf_evt), .top_evt(top_evt), .pwm(pwm)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_buf[g] <= '0;
            else if (wr_en && (int'(wr_addr) == int'(A_CMP0) + g)) cmp_buf[g] <= wr_data;
        end
        tmr3_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm), .dir(dir),
            .top_evt(top_evt), .cnt(cnt), .buf_val(cmp_buf[g]),
            .match(match[g]), .wave(wave_out[g])
        );
    end

    assign flag_set = {match, ovf_evt};
    assign flag_clr = (wr_en && wr_addr == A_FLAG) ? wr_data[NF-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            top_q   <= '0;
            mask_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[7:0];
            if (wr_en && wr_addr == A_TOP)  top_q  <= wr_data;
            if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[NF-1:0];
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    assign irq = |(flags_q & mask_q);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data = {{(W-8){1'b0}}, ctrl_q};
            A_COUNT: rd_data = cnt;
            A_TOP:   rd_data = top_q;
            A_FLAG:  rd_data = {{(W-NF){1'b0}}, flags_q};
            A_MASK:  rd_data = {{(W-NF){1'b0}}, mask_q};
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (int'(rd_addr) == int'(A_CMP0) + i) rd_data = cmp_buf[i];
            end
        endcase
    end

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FLAG && (&wr_data[NF-1:0]) && flag_set == '0) |=> (flags_q == '0)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(wr_en && wr_addr == A_FLAG && wr_data[0])) |=> flags_q[0]); // R10
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && mode == MODE_NORMAL && !cnt_wr) |=> (cnt == '0)); // R4
endmodule

// File: tb/tmr3_timer_bench.sv
module tmr3_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, presc_tick = 1'b0, ext_pin = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  wave_out;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr3_timer u_tmr3_timer (
        .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wave_out(wave_out), .irq(irq)
    );

    int checks = 0, errors = 0;

    logic [15:0] m_cnt = '0, m_top = '0;
    logic [15:0] m_buf [3] = '{default: '0};
    logic [15:0] m_act [3] = '{default: '0};
    logic        m_dir = 1'b0;
    logic [3:0]  m_flags = '0, m_mask = '0;
    logic [2:0]  m_wave = '0;
    logic [7:0]  m_ctrl = '0;

    function automatic logic [15:0] turn_of(logic [7:0] c, logic [15:0] tr);
        return (c[1:0] == 2'd2) ? 16'h00FF : tr;
    endfunction

    function automatic logic exp_irq(logic [3:0] f, logic [3:0] m);
        return |(f & m);
    endfunction

    task automatic model_step(bit t);
        logic tk, pwm, nd, ovf, tev;
        logic [15:0] tv, nc, cmp;
        logic [3:0] set;
        tk  = t && (m_ctrl[3:2] == 2'd1);
        pwm = m_ctrl[1];
        tv  = turn_of(m_ctrl, m_top);
        nc  = m_cnt;
        nd  = pwm ? m_dir : 1'b0;
        ovf = 1'b0;
        tev = 1'b0;
        if (tk) begin
            case (m_ctrl[1:0])
                2'd0: begin nc = m_cnt + 16'd1; ovf = (m_cnt == 16'hFFFF); end
                2'd1: if (m_cnt == tv) begin nc = '0; ovf = 1'b1; tev = 1'b1; end
                      else nc = m_cnt + 16'd1;
                default: begin
                    if (!m_dir) begin
                        if (m_cnt >= tv) begin
                            tev = 1'b1; nd = 1'b1;
                            nc = (m_cnt == 0) ? m_cnt : m_cnt - 16'd1;
                        end else nc = m_cnt + 16'd1;
                    end else begin
                        if (m_cnt == 0) begin
                            ovf = 1'b1; nd = 1'b0;
                            nc = (tv == 0) ? m_cnt : m_cnt + 16'd1;
                        end else nc = m_cnt - 16'd1;
                    end
                end
            endcase
        end
        set = {3'b000, ovf};
        for (int i = 0; i < 3; i++) begin
            cmp = pwm ? m_act[i] : m_buf[i];
            if (tk && m_cnt == cmp) begin
                set[i+1] = 1'b1;
                m_wave[i] = pwm ? !m_dir : !m_wave[i];
            end
        end
        for (int i = 0; i < 3; i++)
            if (!pwm || tev) m_act[i] = m_buf[i];
        m_flags = m_flags | set;
        m_cnt = nc;
        m_dir = nd;
    endtask

    task automatic cyc(bit t);
        presc_tick = t;
        model_step(t);
        @(negedge clk);
        presc_tick = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_step(1'b0);
        case (a)
            3'd0: m_ctrl = d[7:0];
            3'd1: m_cnt = d;
            3'd2, 3'd3, 3'd4: m_buf[a-3'd2] = d;
            3'd5: m_top = d;
            3'd6: m_flags = m_flags & ~d[3:0];
            default: m_mask = d[3:0];
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(string rc);
        logic [15:0] c, f;
        rd(3'd1, c);
        chk(c == m_cnt, rc, "count", c, m_cnt);
        rd(3'd6, f);
        chk(f == {12'h000, m_flags}, "R7", "flags", f, {12'h000, m_flags});
        chk(wave_out == m_wave, "R9", "wave", {13'h0, wave_out}, {13'h0, m_wave});
        chk(irq == exp_irq(m_flags, m_mask), "R11", "irq", {15'h0, irq},
            {15'h0, exp_irq(m_flags, m_mask)});
    endtask

    task automatic pin_pulses(int n);
        for (int k = 0; k < n; k++) begin
            ext_pin = 1'b1; repeat (4) @(negedge clk);
            ext_pin = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check_all("R1");

        // R2: no source selected, ticks ignored
        wr(3'd1, 16'h0040);
        for (int k = 0; k < 6; k++) cyc(1'b1);
        check_all("R2");
        wr(3'd0, 16'h000C);
        for (int k = 0; k < 6; k++) cyc(1'b1);
        check_all("R2");

        // R3: external pin, keep compare values out of the way
        wr(3'd2, 16'h8000); wr(3'd3, 16'h8000); wr(3'd4, 16'h8000);
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0000);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd1, v); chk(v == 16'd0, "R3", "sync latency early", v, 16'd0);
        @(negedge clk);
        rd(3'd1, v); chk(v == 16'd1, "R3", "sync latency step", v, 16'd1);
        repeat (3) @(negedge clk);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        pin_pulses(4);
        rd(3'd1, v); chk(v == 16'd5, "R3", "rising count", v, 16'd5);
        wr(3'd0, 16'h0018);
        wr(3'd1, 16'h0000);
        pin_pulses(3);
        rd(3'd1, v); chk(v == 16'd3, "R3", "falling count", v, 16'd3);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        check_all("R3");

        // R12: count load and readback
        wr(3'd1, 16'h1234);
        rd(3'd1, v); chk(v == 16'h1234, "R12", "count load", v, 16'h1234);
        wr(3'd5, 16'h00A5);
        rd(3'd5, v); chk(v == 16'h00A5, "R12", "limit readback", v, 16'h00A5);

        // R4: wrap sets overflow flag
        wr(3'd1, 16'hFFFE);
        wr(3'd0, 16'h0004);
        cyc(1'b1); check_all("R4");
        cyc(1'b1); check_all("R4");
        rd(3'd6, v); chk(v[0] == 1'b1, "R4", "wrap flag", v, 16'h0001);

        // R11: masking
        wr(3'd7, 16'h0001); check_all("R11");
        chk(irq == 1'b1, "R11", "irq on", {15'h0, irq}, 16'h1);
        wr(3'd7, 16'h000E); check_all("R11");
        chk(irq == 1'b0, "R11", "irq masked", {15'h0, irq}, 16'h0);

        // R10: write-one-to-clear leaves other bits
        wr(3'd2, 16'h0003);
        for (int k = 0; k < 4; k++) cyc(1'b1);
        wr(3'd6, 16'h0001);
        check_all("R10");
        rd(3'd6, v); chk(v == 16'h0002, "R10", "partial clear", v, 16'h0002);
        wr(3'd6, 16'h000F);
        rd(3'd6, v); chk(v == 16'h0000, "R10", "full clear", v, 16'h0000);

        // R8: buffered compare in phase-correct mode with register limit
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'd10); wr(3'd2, 16'd3); wr(3'd3, 16'h8000); wr(3'd4, 16'h8000);
        wr(3'd1, 16'd0); wr(3'd6, 16'h000F);
        wr(3'd0, 16'h0007);
        for (int k = 0; k < 5; k++) begin cyc(1'b1); check_all("R8"); end
        wr(3'd2, 16'd8);
        for (int k = 0; k < 22; k++) begin cyc(1'b1); check_all("R8"); end

        // Random scenarios: R5, R6, R7, R9
        for (int it = 0; it < 8; it++) begin
            int md, ncyc;
            logic [15:0] tp;
            string rc;
            md = it % 4;
            tp = 16'($urandom_range(40, 3));
            rc = (md == 0) ? "R4" : (md == 1) ? "R5" : "R6";
            ncyc = (md == 2) ? 700 : 300;
            wr(3'd0, 16'(md));
            wr(3'd5, tp);
            for (int c = 0; c < 3; c++) wr(3'(2 + c), 16'($urandom_range(int'(tp), 0)));
            wr(3'd1, (md == 0) ? 16'hFF80 : 16'd0);
            wr(3'd6, 16'h000F);
            wr(3'd7, 16'($urandom_range(15, 0)));
            wr(3'd0, 16'(md | 4));
            for (int k = 0; k < ncyc; k++) begin
                if ($urandom_range(39, 0) == 0)
                    wr(3'(2 + $urandom_range(2, 0)), 16'($urandom_range(int'(tp) + 2, 0)));
                else
                    cyc($urandom_range(3, 0) != 0);
                check_all(rc);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule